// File: doc/BRIEF.md
# Sliding Mask Register Unit

This unit holds the mask state that a content-addressable search array uses. There are two wide mask registers. The first has two copies, a foreground and a background, and only one of them is live at a time. The second can slide one bit at a time toward either end. Software-visible data arrives one 16-bit slice per write. A small wrapping pointer chooses the slice and advances after every write.

The unit produces two results. The first is the mask that every search uses. It is taken from either register, or it is switched off, and it always excludes the low RAM bits that the partition setting reserves. The second is a masked merge for writes and moves: a destination bit is replaced by the new value only where the chosen mask holds a 0.

Slides on the second register stay inside the CAM section, bits [WIDTH-1:R], where R is the programmed RAM width. The bit at the limit that the slide moves away from is copied into its neighbour, so the register never rotates and never fills with zeros.

Top module: `slide_mask_unit`

## Requirements
- R1: After reset, every copy of both masks is zero, the slice pointer is 0, the foreground copy of the first mask is live, compare masking is off and the RAM width R is 0.
- R2: When `wr_en` is 1, `wr_data` is written to bits [16k+15:16k] of the target, where k is the slice pointer. The target code `wr_tgt` means 0 = first mask foreground, 1 = first mask background, 2 = second mask, 3 = nothing written. The pointer then advances by one modulo 4 for every target code, and a register that is not targeted keeps its value.
- R3: When `ptr_ld` is 1, the pointer takes `ptr_val` on the next edge. This applies even if a write happens in the same cycle, and that write still uses the old pointer.
- R4: `bank_ld` loads `bank_val`, where 1 makes the background copy live and 0 makes the foreground copy live. Wherever "first mask" is selected below, it means the live copy.
- R5: `cmp_ld` loads the compare mode `cmp_val`: 0 = off, 1 = first mask, 2 = second mask, 3 = off. When the mode is off, `cmp_mask` is 0 in every CAM bit. Otherwise the CAM bits of `cmp_mask` are equal to the chosen mask, where 1 means excluded from the compare.
- R6: `part_ld` loads R from `part_val`. Bits [R-1:0] of `cmp_mask` are always 1, whatever the mode.
- R7: `merge_out` bit i is `merge_old[i]` when the chosen mask bit i is 1, and `merge_new[i]` otherwise. `merge_sel` uses the same codes as R5, where 0 and 3 mean no mask, so `merge_out` equals `merge_new`.
- R8: When only `shr` is asserted, the second mask takes bit i+1 into bit i for R <= i < WIDTH-1, and bit WIDTH-1 is kept.
- R9: When only `shl` is asserted, the second mask takes bit i-1 into bit i for R < i <= WIDTH-1, and bit R is kept.
- R10: Shifts never change bits below R. When R = WIDTH-1, a shift changes nothing.
- R11: When `shl` and `shr` are both asserted, the second mask does not change. A write that targets the second mask in the same cycle as a shift takes effect, and the shift is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Slice write strobe |
| wr_tgt | input | 2 | Write target code |
| wr_data | input | 16 | Slice data |
| ptr_ld | input | 1 | Load the slice pointer |
| ptr_val | input | 2 | New slice pointer |
| bank_ld | input | 1 | Load the live-copy select |
| bank_val | input | 1 | 1 = background copy live |
| cmp_ld | input | 1 | Load the compare mode |
| cmp_val | input | 2 | Compare mode code |
| part_ld | input | 1 | Load the RAM width |
| part_val | input | 6 | RAM width R |
| shl | input | 1 | Slide the second mask left |
| shr | input | 1 | Slide the second mask right |
| merge_sel | input | 2 | Mask choice for the merge |
| merge_old | input | 64 | Current destination value |
| merge_new | input | 64 | Incoming value |
| cmp_mask | output | 64 | Effective compare mask (1 = excluded) |
| merge_out | output | 64 | Masked merge result |

## Verification
The hardest states to reach are slides with a non-zero RAM width and a sparse second mask. In these states an error in the limit bit or in the protection of the low bits shows up only as one wrong bit. R = WIDTH-1 is also hard to reach, because there every slide must do nothing. The stimulus reaches these states with directed sequences that load a known pattern, set R to 0, 20 and 63, and apply runs of single slides. Random cycles with a fixed seed then mix writes, pointer loads, mode changes, and shifts that clash with each other or with writes. Every cycle checks both outputs against a bench model, using random merge operands, so the full contents of each mask are visible through `merge_out`.

// File: rtl/slide_mask_unit.sv
module slide_mask_unit #(
  parameter int WIDTH = 64,
  parameter int SEG_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_tgt,
  input  logic [SEG_W-1:0]           wr_data,
  input  logic                       ptr_ld,
  input  logic [$clog2(WIDTH/SEG_W)-1:0] ptr_val,
  input  logic                       bank_ld,
  input  logic                       bank_val,
  input  logic                       cmp_ld,
  input  logic [1:0]                 cmp_val,
  input  logic                       part_ld,
  input  logic [$clog2(WIDTH)-1:0]   part_val,
  input  logic                       shl,
  input  logic                       shr,
  input  logic [1:0]                 merge_sel,
  input  logic [WIDTH-1:0]           merge_old,
  input  logic [WIDTH-1:0]           merge_new,
  output logic [WIDTH-1:0]           cmp_mask,
  output logic [WIDTH-1:0]           merge_out
);
  localparam int NSEG  = WIDTH / SEG_W;
  localparam int PTR_W = $clog2(NSEG);
  localparam int RAM_W = $clog2(WIDTH);

  logic [WIDTH-1:0] mr1_fg, mr1_bg, mr2;
  logic [PTR_W-1:0] ptr_q;
  logic             bank_q;
  logic [1:0]       cmode_q;
  logic [RAM_W-1:0] ram_q;

  logic [WIDTH-1:0] mr1_live, ram_mask, shr_vec, shl_vec, cmp_src, mrg_src;
  logic             wr_mr2;

  assign mr1_live = bank_q ? mr1_bg : mr1_fg;
  assign ram_mask = ({{(WIDTH-1){1'b0}}, 1'b1} << ram_q) - 1'b1;
  assign wr_mr2   = wr_en && (wr_tgt == 2'd2);

  always_comb begin
    shr_vec = mr2;
    for (int i = 0; i < WIDTH-1; i++)
      if (i >= int'(ram_q)) shr_vec[i] = mr2[i+1];
  end

  always_comb begin
    shl_vec = mr2;
    for (int i = 1; i < WIDTH; i++)
      if (i > int'(ram_q)) shl_vec[i] = mr2[i-1];
  end

  always_comb begin
    case (cmode_q)
      2'd1:    cmp_src = mr1_live;
      2'd2:    cmp_src = mr2;
      default: cmp_src = '0;
    endcase
  end

  always_comb begin
    case (merge_sel)
      2'd1:    mrg_src = mr1_live;
      2'd2:    mrg_src = mr2;
      default: mrg_src = '0;
    endcase
  end

  assign cmp_mask  = cmp_src | ram_mask;
  assign merge_out = (merge_new & ~mrg_src) | (merge_old & mrg_src);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mr1_fg  <= '0;
      mr1_bg  <= '0;
      mr2     <= '0;
      ptr_q   <= '0;
      bank_q  <= 1'b0;
      cmode_q <= 2'd0;
      ram_q   <= '0;
    end else begin
      if (wr_en) begin
        case (wr_tgt)
          2'd0: mr1_fg[ptr_q*SEG_W +: SEG_W] <= wr_data;
          2'd1: mr1_bg[ptr_q*SEG_W +: SEG_W] <= wr_data;
          2'd2: mr2[ptr_q*SEG_W +: SEG_W]    <= wr_data;
          default: ;
        endcase
      end
      if (!wr_mr2) begin
        if (shr && !shl)      mr2 <= shr_vec;
        else if (shl && !shr) mr2 <= shl_vec;
      end
      if (ptr_ld)     ptr_q <= ptr_val;
      else if (wr_en) ptr_q <= ptr_q + 1'b1;
      if (bank_ld) bank_q  <= bank_val;
      if (cmp_ld)  cmode_q <= cmp_val;
      if (part_ld) ram_q   <= part_val;
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !ptr_ld |=> ptr_q == $past(ptr_q) + 1'b1); // R2
  AST_MR1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_tgt <= 2'd1) |=> $stable(mr1_fg) && $stable(mr1_bg)); // R2
  AST_SHR_TOP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    shr && !shl && !wr_mr2 |=> mr2[WIDTH-1] == $past(mr2[WIDTH-1])); // R8
  AST_LOW_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (shr || shl) && !wr_mr2 |=> (mr2 & $past(ram_mask)) == ($past(mr2) & $past(ram_mask))); // R10
  AST_BOTH_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    shr && shl && !wr_mr2 |=> $stable(mr2)); // R11
endmodule

// File: tb/slide_mask_unit_tb.sv
module slide_mask_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, ptr_ld = 0, bank_ld = 0, bank_val = 0, cmp_ld = 0, part_ld = 0, shl = 0, shr = 0;
  logic [1:0] wr_tgt = 0, ptr_val = 0, cmp_val = 0, merge_sel = 0;
  logic [15:0] wr_data = 0;
  logic [5:0] part_val = 0;
  logic [W-1:0] merge_old = 0, merge_new = 0, cmp_mask, merge_out;

  int tests = 0, fails = 0;

  logic [W-1:0] m1f, m1b, m2;
  logic [1:0] ptr, cmode;
  logic bank;
  int ram;

  slide_mask_unit u_dut (.clk, .rst_n, .wr_en, .wr_tgt, .wr_data, .ptr_ld, .ptr_val,
    .bank_ld, .bank_val, .cmp_ld, .cmp_val, .part_ld, .part_val, .shl, .shr,
    .merge_sel, .merge_old, .merge_new, .cmp_mask, .merge_out);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [W-1:0] pick(input logic [1:0] code);
    if (code == 2'd1) return bank ? m1b : m1f;
    if (code == 2'd2) return m2;
    return '0;
  endfunction

  function automatic logic [W-1:0] low_bits(input int r);
    logic [W-1:0] v = '0;
    for (int i = 0; i < r; i++) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [W-1:0] slide_r(input logic [W-1:0] v, input int r);
    logic [W-1:0] o = v;
    for (int i = r; i < W-1; i++) o[i] = v[i+1];
    return o;
  endfunction

  function automatic logic [W-1:0] slide_l(input logic [W-1:0] v, input int r);
    logic [W-1:0] o = v;
    for (int i = W-1; i > r; i--) o[i] = v[i-1];
    return o;
  endfunction

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(input string tag);
    logic [W-1:0] em;
    #1;
    em = pick(merge_sel);
    check(cmp_mask, pick(cmode) | low_bits(ram), {tag, " R5 R6 cmp_mask"});
    check(merge_out, (merge_new & ~em) | (merge_old & em), {tag, " R7 merge_out"});
    @(posedge clk);
    if (rst_n) begin
      if (wr_en) begin
        if (wr_tgt == 2'd0) m1f[ptr*16 +: 16] = wr_data;
        if (wr_tgt == 2'd1) m1b[ptr*16 +: 16] = wr_data;
        if (wr_tgt == 2'd2) m2[ptr*16 +: 16] = wr_data;
      end
      if (!(wr_en && wr_tgt == 2'd2)) begin
        if (shr && !shl) m2 = slide_r(m2, ram);
        else if (shl && !shr) m2 = slide_l(m2, ram);
      end
      if (ptr_ld) ptr = ptr_val; else if (wr_en) ptr = ptr + 2'd1;
      if (bank_ld) bank = bank_val;
      if (cmp_ld) cmode = cmp_val;
      if (part_ld) ram = int'(part_val);
    end
    @(negedge clk);
    {wr_en, ptr_ld, bank_ld, cmp_ld, part_ld, shl, shr} = '0;
    merge_old = {$urandom, $urandom};
    merge_new = {$urandom, $urandom};
    merge_sel = 2'($urandom);
  endtask

  task automatic wr(input logic [1:0] t, input logic [15:0] d);
    wr_en = 1; wr_tgt = t; wr_data = d; cycle("R2 write");
  endtask

  initial begin
    void'($urandom(32'h5EED));
    m1f = '0; m1b = '0; m2 = '0; ptr = 0; cmode = 0; bank = 0; ram = 0;
    @(negedge clk);
    cycle("R1 in reset");
    rst_n = 1;
    merge_sel = 2'd1; merge_old = '0; merge_new = '1;
    cycle("R1 after reset");
    // R2 fill all four slices of each register, plus the ignored code 3
    for (int k = 0; k < 4; k++) wr(2'd0, 16'h1111 * 16'(k+1));
    for (int k = 0; k < 4; k++) wr(2'd1, 16'hA5A5 ^ 16'(k));
    wr(2'd3, 16'hFFFF);
    ptr_ld = 1; ptr_val = 0; cycle("R3 ptr load");
    for (int k = 0; k < 4; k++) wr(2'd2, k == 3 ? 16'h8000 : 16'h0000);
    // R3 load during write
    ptr_ld = 1; ptr_val = 2; wr_en = 1; wr_tgt = 2'd0; wr_data = 16'hBEEF; cycle("R3 load with write");
    // R4 live copy switch, R5 modes
    bank_ld = 1; bank_val = 1; cmp_ld = 1; cmp_val = 2'd1; cycle("R4 bank");
    merge_sel = 2'd1; cycle("R4 background live");
    cmp_ld = 1; cmp_val = 2'd3; cycle("R5 off");
    cmp_ld = 1; cmp_val = 2'd2; cycle("R5 mr2");
    // R8 slides from top with R=0
    for (int k = 0; k < 5; k++) begin shr = 1; cycle("R8 slide right"); end
    // R9 slide left with R=20, R10 low bits kept
    part_ld = 1; part_val = 6'd20; cycle("R6 part load");
    ptr_ld = 1; ptr_val = 0; cycle("R3");
    wr(2'd2, 16'h0013);
    wr(2'd2, 16'h0010);
    for (int k = 0; k < 6; k++) begin shl = 1; cycle("R9 slide left"); end
    for (int k = 0; k < 3; k++) begin shr = 1; cycle("R10 slide right R20"); end
    // R10 limit R=63
    part_ld = 1; part_val = 6'd63; cycle("R6 part 63");
    shl = 1; cycle("R10 no change left");
    shr = 1; cycle("R10 no change right");
    part_ld = 1; part_val = 6'd0; cycle("R6 part 0");
    // R11 clashes
    shl = 1; shr = 1; cycle("R11 both");
    shr = 1; wr_en = 1; wr_tgt = 2'd2; wr_data = 16'h00F0; cycle("R11 write wins");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      wr_en   = ($urandom % 10) < 4;
      wr_tgt  = 2'($urandom);
      wr_data = 16'($urandom);
      ptr_ld  = ($urandom % 10) == 0;
      ptr_val = 2'($urandom);
      bank_ld = ($urandom % 10) == 0;
      bank_val = 1'($urandom);
      cmp_ld  = ($urandom % 10) == 0;
      cmp_val = 2'($urandom);
      part_ld = ($urandom % 20) == 0;
      part_val = ($urandom % 4 == 0) ? 6'd63 : 6'($urandom % 24);
      shl = ($urandom % 10) < 3;
      shr = ($urandom % 10) < 3;
      cycle("random");
    end
    rst_n = 0;
    cycle("R1 reapply");
    m1f = '0; m1b = '0; m2 = '0; ptr = 0; cmode = 0; bank = 0; ram = 0;
    rst_n = 1;
    merge_sel = 2'd2;
    cycle("R1 after second reset");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule